// File: doc/BRIEF.md
# Interrupt Distributor with Pending/Active Tracking

This block gathers a set of device interrupt lines, numbers each line by its position, and presents one registered IRQ request to a single CPU. Each interrupt has its own enable bit, a choice of edge or level sensing, a priority value and an 8-bit routing field. A two-bit state of pending and active flags is kept for every interrupt. The CPU takes an interrupt by reading an acknowledge register and releases it by writing its ID to an end-of-interrupt register.

Software reaches the block through a simple single-cycle register bus. A transaction is one cycle of `req_i`, and `we_i` gives its direction. Read data comes back on the following cycle with `rvalid_o`. Word addresses: 0x00 control (bit 0 enables the CPU interface), 0x01 enable-set, 0x02 enable-clear, 0x03 trigger mode (bit i = 1 makes interrupt i edge-sensitive), 0x04 acknowledge (read), 0x05 end-of-interrupt (write, ID in bits 9:0), 0x06 pending flags (read), 0x07 active flags (read). Priorities sit from 0x20 upward, eight 4-bit fields per word, with interrupt i in word i/8 at bits 4*(i%8)+3:4*(i%8). Routing sits from 0x40 upward, four 8-bit fields per word, with interrupt i in word i/4 at bits 8*(i%4)+7:8*(i%4). Bit 0 of a routing field selects this CPU.

Top module: `irq_dist`

## Requirements
- R1: After reset every enable, mode, pending and active bit reads 0, `irq_o` is 0, and an acknowledge read returns 1023.
- R2: A level-sensitive interrupt shows as pending one clock after its line rises and stops being pending one clock after the line falls.
- R3: An edge-sensitive interrupt becomes pending on a rising edge of its line and stays pending after the line drops, until it is acknowledged.
- R4: An acknowledge read returns the ID of the eligible interrupt with the lowest priority value, with ties going to the lower ID. An interrupt is eligible when it is pending, not active, enabled and routed here.
- R5: Acknowledging an edge-sensitive interrupt clears its pending flag and sets its active flag.
- R6: Acknowledging a level-sensitive interrupt whose line is still high sets its active flag and leaves it pending, so both flags read 1.
- R7: Writing an ID to end-of-interrupt clears that interrupt's active flag. Writing the ID of an interrupt that is not active changes no flag.
- R8: A write to enable-set sets the enables at its 1 bits, and a write to enable-clear clears them. Bits written as 0 leave their enables unchanged.
- R9: An interrupt whose routing field has bit 0 clear is never signalled or acknowledged, even when pending and enabled.
- R10: A disabled interrupt still records pending state but does not drive `irq_o`.
- R11: An acknowledge read with nothing eligible returns 1023 and leaves all active flags unchanged.
- R12: `irq_o` is a register. It rises one clock after an interrupt becomes eligible, and only while the control enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_line_i | input | NUM_IRQ | Device interrupt lines, bit i is ID i |
| req_i | input | 1 | Bus transaction valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, one cycle after the read |
| rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The hardest case to reach is the Active+Pending state of a level source. It needs a line held high across an acknowledge read, then a check that the interrupt is not offered again before end-of-interrupt. The bench holds the line, acknowledges, reads both flag registers and then issues a second acknowledge that must come back spurious. It then releases the line before writing end-of-interrupt. Priority ties are set up by pulsing three edge sources in the same cycle, two of them with equal priority, and the bench acknowledges them one after another.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int ID_W        = 10;
  localparam int SPURIOUS_ID = 1023;

  localparam int A_CTRL      = 'h00;
  localparam int A_EN_SET    = 'h01;
  localparam int A_EN_CLR    = 'h02;
  localparam int A_MODE      = 'h03;
  localparam int A_ACK       = 'h04;
  localparam int A_EOI       = 'h05;
  localparam int A_PEND      = 'h06;
  localparam int A_ACTV      = 'h07;
  localparam int A_PRIO_BASE = 'h20;
  localparam int A_TGT_BASE  = 'h40;

  // encoding is {active, pending}
  typedef enum logic [1:0] {
    ST_IDLE     = 2'b00,
    ST_PEND     = 2'b01,
    ST_ACT      = 2'b10,
    ST_ACT_PEND = 2'b11
  } irq_state_e;
endpackage

// File: rtl/irq_src.sv
module irq_src
  import irq_dist_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic edge_i,
  input  logic ack_i,
  input  logic eoi_i,
  output logic pend_o,
  output logic act_o
);
  irq_state_e state_q;
  logic       line_q, pend_n, act_n;

  assign pend_o = state_q[0];
  assign act_o  = state_q[1];

  always_comb begin
    act_n = (act_o | ack_i) & ~eoi_i;
    if (edge_i) pend_n = (pend_o & ~ack_i) | (line_i & ~line_q);
    else        pend_n = line_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      line_q  <= 1'b0;
    end else begin
      state_q <= irq_state_e'({act_n, pend_n});
      line_q  <= line_i;
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int N      = 8,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 3
) (
  input  logic [N-1:0]      elig_i,
  input  logic [PRIO_W-1:0] prio_i [N],
  output logic              valid_o,
  output logic [IDX_W-1:0]  win_o
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    valid_o = 1'b0;
    win_o   = '0;
    best    = '1;
    for (int i = 0; i < N; i++) begin
      // strict compare keeps the lower ID on ties
      if (elig_i[i] && (!valid_o || prio_i[i] < best)) begin
        valid_o = 1'b1;
        win_o   = IDX_W'(i);
        best    = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_line_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o,
  output logic               irq_o
);
  localparam int IDX_W      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int PRIO_PER_W = DATA_W / PRIO_W;
  localparam int TGT_W      = 8;
  localparam int TGT_PER_W  = DATA_W / TGT_W;

  logic               cpu_en_q;
  logic [NUM_IRQ-1:0] en_q, mode_q;
  logic [PRIO_W-1:0]  prio_q [NUM_IRQ];
  logic [TGT_W-1:0]   tgt_q  [NUM_IRQ];

  logic [NUM_IRQ-1:0] pend, act, elig, ack_vec, eoi_hit;
  logic               win_valid, wr, rd, ack_fire;
  logic [IDX_W-1:0]   win;
  logic [DATA_W-1:0]  rd_mux;

  assign wr       = req_i & we_i;
  assign rd       = req_i & ~we_i;
  assign ack_fire = rd && (addr_i == ADDR_W'(A_ACK));

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
    assign elig[g]    = pend[g] & ~act[g] & en_q[g] & tgt_q[g][0];
    assign ack_vec[g] = ack_fire & win_valid & (win == IDX_W'(g));
    assign eoi_hit[g] = wr && (addr_i == ADDR_W'(A_EOI)) &&
                        (wdata_i[ID_W-1:0] == ID_W'(g));
    irq_src i_src (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(irq_line_i[g]),
      .edge_i(mode_q[g]),
      .ack_i (ack_vec[g]),
      .eoi_i (eoi_hit[g]),
      .pend_o(pend[g]),
      .act_o (act[g])
    );
  end

  irq_arb #(.N(NUM_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) i_arb (
    .elig_i (elig),
    .prio_i (prio_q),
    .valid_o(win_valid),
    .win_o  (win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_en_q <= 1'b0;
      en_q     <= '0;
      mode_q   <= '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        prio_q[i] <= '0;
        tgt_q[i]  <= '0;
      end
    end else if (wr) begin
      if (addr_i == ADDR_W'(A_CTRL))   cpu_en_q <= wdata_i[0];
      if (addr_i == ADDR_W'(A_EN_SET)) en_q     <= en_q | wdata_i[NUM_IRQ-1:0];
      if (addr_i == ADDR_W'(A_EN_CLR)) en_q     <= en_q & ~wdata_i[NUM_IRQ-1:0];
      if (addr_i == ADDR_W'(A_MODE))   mode_q   <= wdata_i[NUM_IRQ-1:0];
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (addr_i == ADDR_W'(A_PRIO_BASE + i / PRIO_PER_W))
          prio_q[i] <= wdata_i[(i % PRIO_PER_W) * PRIO_W +: PRIO_W];
        if (addr_i == ADDR_W'(A_TGT_BASE + i / TGT_PER_W))
          tgt_q[i] <= wdata_i[(i % TGT_PER_W) * TGT_W +: TGT_W];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_W'(A_CTRL):   rd_mux[0] = cpu_en_q;
      ADDR_W'(A_EN_SET),
      ADDR_W'(A_EN_CLR): rd_mux = DATA_W'(en_q);
      ADDR_W'(A_MODE):   rd_mux = DATA_W'(mode_q);
      ADDR_W'(A_ACK):    rd_mux = win_valid ? DATA_W'(win) : DATA_W'(SPURIOUS_ID);
      ADDR_W'(A_PEND):   rd_mux = DATA_W'(pend);
      ADDR_W'(A_ACTV):   rd_mux = DATA_W'(act);
      default: begin
        for (int i = 0; i < NUM_IRQ; i++) begin
          if (addr_i == ADDR_W'(A_PRIO_BASE + i / PRIO_PER_W))
            rd_mux[(i % PRIO_PER_W) * PRIO_W +: PRIO_W] = prio_q[i];
          if (addr_i == ADDR_W'(A_TGT_BASE + i / TGT_PER_W))
            rd_mux[(i % TGT_PER_W) * TGT_W +: TGT_W] = tgt_q[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_mux;
      irq_o <= cpu_en_q & win_valid;
    end
  end
endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             cpu_en,
  input logic [N-1:0]     elig,
  input logic [N-1:0]     act,
  input logic [N-1:0]     eoi_hit,
  input logic             ack_fire,
  input logic             win_valid,
  input logic [IDX_W-1:0] win,
  input logic [31:0]      rdata
);
  // R12
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_en |=> !irq_o);
  // R12
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_en && win_valid) |=> irq_o);
  // R10
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|elig) |=> !irq_o);
  // R4
  win_elig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid |-> elig[win]);
  // R11
  spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && !win_valid) |=> (rdata[9:0] == 10'd1023) && $stable(act));
  // R5
  ack_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && win_valid) |=> ($countones(act) == $countones($past(act)) + 1));
  // R7
  eoi_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|eoi_hit) |=> ((act & $past(eoi_hit)) == '0));
endmodule

bind irq_dist irq_dist_chk #(.N(NUM_IRQ), .IDX_W(IDX_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .cpu_en   (cpu_en_q),
  .elig     (elig),
  .act      (act),
  .eoi_hit  (eoi_hit),
  .ack_fire (ack_fire),
  .win_valid(win_valid),
  .win      (win),
  .rdata    (32'(rdata_o))
);

// File: tb/test_irq_dist.sv
`timescale 1ns/1ps
module test_irq_dist;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] line = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  irq_dist #(.NUM_IRQ(N)) i_irq_dist (
    .clk_i(clk), .rst_ni(rst_n), .irq_line_i(line),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq)
  );

  // monitor: pop expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read: actual %h expected none", rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq_o: actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk_irq(1'b0, "R1");
    rd(8'h01, 32'h0, "R1 enable");
    rd(8'h06, 32'h0, "R1 pending");
    rd(8'h07, 32'h0, "R1 active");
    rd(8'h04, 32'd1023, "R1 ack");

    wr(8'h01, 32'h05);
    rd(8'h01, 32'h05, "R8 set");
    wr(8'h01, 32'h02);
    rd(8'h01, 32'h07, "R8 zero bits keep");
    wr(8'h02, 32'h04);
    rd(8'h02, 32'h03, "R8 clear");
    wr(8'h01, 32'hFF);

    wr(8'h03, 32'h0F);
    wr(8'h20, 32'h41623357);
    wr(8'h40, 32'h01010101);
    wr(8'h41, 32'h01010101);
    wr(8'h00, 32'h1);

    // level source 4
    line[4] = 1'b1;
    step(1); chk_irq(1'b0, "R12 registered");
    step(1); chk_irq(1'b1, "R12 raise");
    rd(8'h06, 32'h10, "R2 level pending");
    line[4] = 1'b0;
    step(2);
    rd(8'h06, 32'h00, "R2 level drop");
    chk_irq(1'b0, "R2 irq drop");

    // edge sources 1..3 pulsed together
    line[3:1] = 3'b111;
    step(1);
    line[3:1] = 3'b000;
    step(2);
    rd(8'h06, 32'h0E, "R3 edge held");
    chk_irq(1'b1, "R3 irq");
    rd(8'h04, 32'd2, "R4 lowest prio low id");
    rd(8'h07, 32'h04, "R5 active");
    rd(8'h06, 32'h0A, "R5 pending cleared");
    rd(8'h04, 32'd3, "R4 next");
    rd(8'h04, 32'd1, "R4 last");
    rd(8'h04, 32'd1023, "R11 spurious");
    rd(8'h07, 32'h0E, "R11 no change");
    step(2);
    chk_irq(1'b0, "R4 active excluded");
    wr(8'h05, 32'd5);
    rd(8'h07, 32'h0E, "R7 eoi not active");
    wr(8'h05, 32'd2);
    rd(8'h07, 32'h0A, "R7 eoi clear");
    wr(8'h05, 32'd3);
    wr(8'h05, 32'd1);
    rd(8'h07, 32'h00, "R7 all clear");

    // level acknowledge while held
    line[4] = 1'b1;
    step(2);
    rd(8'h04, 32'd4, "R6 ack level");
    rd(8'h06, 32'h10, "R6 still pending");
    rd(8'h07, 32'h10, "R6 active");
    rd(8'h04, 32'd1023, "R6 not re-offered");
    line[4] = 1'b0;
    step(2);
    wr(8'h05, 32'd4);
    rd(8'h07, 32'h00, "R7 level eoi");

    // routing
    wr(8'h41, 32'h01020101);
    line[6] = 1'b1;
    step(3);
    chk_irq(1'b0, "R9 other cpu");
    rd(8'h06, 32'h40, "R9 pending recorded");
    rd(8'h04, 32'd1023, "R9 ack");
    wr(8'h41, 32'h01010101);
    step(2);
    chk_irq(1'b1, "R9 routed");
    rd(8'h04, 32'd6, "R9 ack routed");
    line[6] = 1'b0;
    step(2);
    wr(8'h05, 32'd6);

    // disable
    wr(8'h02, 32'h20);
    line[5] = 1'b1;
    step(3);
    chk_irq(1'b0, "R10 disabled");
    rd(8'h06, 32'h20, "R10 pending");
    rd(8'h01, 32'hDF, "R8 clear one");
    wr(8'h01, 32'h20);
    step(2);
    chk_irq(1'b1, "R10 enabled");
    rd(8'h04, 32'd5, "R10 ack");
    line[5] = 1'b0;
    step(2);
    wr(8'h05, 32'd5);

    // CPU interface gate
    wr(8'h00, 32'h0);
    line[7] = 1'b1;
    step(3);
    chk_irq(1'b0, "R12 gated");
    wr(8'h00, 32'h1);
    step(2);
    chk_irq(1'b1, "R12 ungated");
    rd(8'h04, 32'd7, "R4 id 7");

    step(4);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule